// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block decides, once per machine cycle, whether the processor core should break into the running program and where it should jump. Up to ten request flags are sampled at a single late point of each machine cycle, marked by a strobe from the core. The sample is masked by a global enable and by one enable bit per source. The samples are judged at the strobe of the following machine cycle. Each source carries a one-bit priority level. A winner is chosen first by level and then by a fixed ordering of the sources. When nothing blocks the call, the block emits a one-clock acknowledge that carries the call address. The core then performs the call and saves only the program counter.

The block keeps one busy bit for each priority level. An acknowledge sets the busy bit of its level. The end of a return-from-interrupt instruction clears the higher of the busy bits that are set. A busy level holds off new requests at that level and at any lower level. A high-level request can still interrupt a low-level handler. A blocked request leaves no record behind. If its flag is gone at the next sample, it is never serviced.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Request flags are captured only at the clock edge where `sampleStb` is high, masked by `globalEn` and `srcEn`. A decision at a strobe uses the flags captured at the previous strobe. Flag activity between strobes has no effect.
- R2: An acknowledge is issued only at a strobe where `lastCycle` is high.
- R3: No acknowledge is issued at a strobe where `retiInstr` or `ieIpAccess` is high.
- R4: A pending source whose `srcPrio` bit is 1 (high level) wins over any source at level 0. Within one level, the lowest source index wins.
- R5: The acknowledged address is 0003h + 8 × index. The index order is: external input 0 = 0, timer 0 = 1, external input 1 = 2, timer 1 = 3, first serial port = 4, timer 2 = 5, second serial port = 6, USB = 7, I2C = 8, display data channel = 9.
- R6: An acknowledge sets the busy bit of its level. While the high busy bit is set, nothing is acknowledged. While only the low busy bit is set, only high-level sources are acknowledged.
- R7: A strobe with both `lastCycle` and `retiInstr` high clears the high busy bit if it is set, and otherwise clears the low busy bit.
- R8: A request that was blocked and whose flag is low at the next sample is not serviced later.
- R9: After reset, `ackPulse`, both busy bits and `ackVector` are 0. `ackPulse` is high for exactly one clock per acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| sampleStb | input | 1 | Marks the sampling point of a machine cycle |
| reqFlags | input | 10 | Interrupt request flags, one per source |
| globalEn | input | 1 | Master enable for all sources |
| srcEn | input | 10 | Per-source enable |
| srcPrio | input | 10 | Per-source level, 1 = high |
| lastCycle | input | 1 | Current machine cycle ends the instruction |
| retiInstr | input | 1 | Current instruction is return-from-interrupt |
| ieIpAccess | input | 1 | Current instruction accesses the enable or priority register |
| ackPulse | output | 1 | One-clock call request |
| ackVector | output | 16 | Call address for the acknowledged source |
| ackSrc | output | 4 | Index of the acknowledged source |
| ackHigh | output | 1 | Acknowledged source was at the high level |
| inProgHigh | output | 1 | High-level handler in progress |
| inProgLow | output | 1 | Low-level handler in progress |

## Verification
The hardest case to reach is preemption followed by staged unwinding. A low-level handler has to be acknowledged first. A high-level source must then be acknowledged on top of it. Two returns must then release exactly one level each. The stimulus gets there by driving machine cycles one after another. A bench model of the sample register and the busy bits predicts every acknowledge into a scoreboard queue. Between strobes the flags are forced to all ones, so any capture outside the strobe turns up as an unexpected address.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef struct packed {
    logic capture;
    logic loadHigh;
    logic loadLow;
  } irqc_strobe_t;
endpackage

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NSRC       = 10,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter int SRCW       = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  irqc_strobe_t     strb,
  input  logic [NSRC-1:0]  reqFlags,
  input  logic [NSRC-1:0]  srcEn,
  input  logic             globalEn,
  input  logic [NSRC-1:0]  srcPrio,
  output logic             hiAny,
  output logic             loAny,
  output logic [VEC_W-1:0] ackVector,
  output logic [SRCW-1:0]  ackSrc
);

  logic [NSRC-1:0] gated;
  logic [NSRC-1:0] sampled;
  logic [NSRC-1:0] hiReq;
  logic [NSRC-1:0] loReq;
  logic [SRCW-1:0] hiIdx;
  logic [SRCW-1:0] loIdx;
  logic [SRCW-1:0] winIdx;
  logic [VEC_W-1:0] winVec;

  // per-source masking ahead of the sample register
  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    assign gated[g] = reqFlags[g] & srcEn[g] & globalEn;
    assign hiReq[g] = sampled[g] & srcPrio[g];
    assign loReq[g] = sampled[g] & ~srcPrio[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sampled <= '0;
    else if (strb.capture) sampled <= gated;
  end

  function automatic logic [SRCW-1:0] lowestSet(input logic [NSRC-1:0] v);
    logic [SRCW-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = SRCW'(i);
    end
    return r;
  endfunction

  assign hiAny  = |hiReq;
  assign loAny  = |loReq;
  assign hiIdx  = lowestSet(hiReq);
  assign loIdx  = lowestSet(loReq);
  assign winIdx = strb.loadHigh ? hiIdx : loIdx;
  assign winVec = VEC_W'(VEC_BASE + VEC_STRIDE * int'(winIdx));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackVector <= '0;
      ackSrc    <= '0;
    end else if (strb.loadHigh || strb.loadLow) begin
      ackVector <= winVec;
      ackSrc    <= winIdx;
    end
  end

  // R1: the sample register moves only on a capture strobe
  p_sample_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(sampled));

  // R4: a low-level grant never happens while a high-level request waits
  p_low_yields_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadLow |-> !hiAny);

  p_single_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadHigh, strb.loadLow}));

endmodule

// File: rtl/irqc_control.sv
module irqc_control
  import irqc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleStb,
  input  logic         lastCycle,
  input  logic         retiInstr,
  input  logic         ieIpAccess,
  input  logic         hiAny,
  input  logic         loAny,
  output irqc_strobe_t strb,
  output logic         ackPulse,
  output logic         ackHigh,
  output logic         inProgHigh,
  output logic         inProgLow
);

  logic pollOk;
  logic retiEnd;
  logic grantHigh;
  logic grantLow;

  assign pollOk    = sampleStb && lastCycle && !retiInstr && !ieIpAccess;
  assign retiEnd   = sampleStb && lastCycle && retiInstr;
  assign grantHigh = pollOk && hiAny && !inProgHigh;
  assign grantLow  = pollOk && !grantHigh && loAny && !inProgHigh && !inProgLow;

  always_comb begin
    strb          = '0;
    strb.capture  = sampleStb;
    strb.loadHigh = grantHigh;
    strb.loadLow  = grantLow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackPulse   <= 1'b0;
      ackHigh    <= 1'b0;
      inProgHigh <= 1'b0;
      inProgLow  <= 1'b0;
    end else begin
      ackPulse <= grantHigh || grantLow;
      if (grantHigh || grantLow) ackHigh <= grantHigh;
      if (grantHigh) inProgHigh <= 1'b1;
      else if (retiEnd && inProgHigh) inProgHigh <= 1'b0;
      if (grantLow) inProgLow <= 1'b1;
      else if (retiEnd && !inProgHigh) inProgLow <= 1'b0;
    end
  end

  // R2 and R3: an acknowledge follows only an unblocked final-cycle strobe
  p_ack_gated_r2: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> $past(sampleStb && lastCycle && !retiInstr && !ieIpAccess));

  // R6: the acknowledged level is marked busy
  p_busy_marked_r6: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> (ackHigh ? inProgHigh : inProgLow));

  // R6: nothing is acknowledged while the high level is busy
  p_high_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && inProgHigh) |=> !ackPulse);

  // R7: a return releases the high level first
  p_reti_high_first_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && lastCycle && retiInstr && inProgHigh) |=> (!inProgHigh && $stable(inProgLow)));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC       = 10,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  localparam int SRCW      = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleStb,
  input  logic [NSRC-1:0]  reqFlags,
  input  logic             globalEn,
  input  logic [NSRC-1:0]  srcEn,
  input  logic [NSRC-1:0]  srcPrio,
  input  logic             lastCycle,
  input  logic             retiInstr,
  input  logic             ieIpAccess,
  output logic             ackPulse,
  output logic [VEC_W-1:0] ackVector,
  output logic [SRCW-1:0]  ackSrc,
  output logic             ackHigh,
  output logic             inProgHigh,
  output logic             inProgLow
);

  irqc_strobe_t strb;
  logic hiAny;
  logic loAny;

  irqc_control ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .sampleStb  (sampleStb),
    .lastCycle  (lastCycle),
    .retiInstr  (retiInstr),
    .ieIpAccess (ieIpAccess),
    .hiAny      (hiAny),
    .loAny      (loAny),
    .strb       (strb),
    .ackPulse   (ackPulse),
    .ackHigh    (ackHigh),
    .inProgHigh (inProgHigh),
    .inProgLow  (inProgLow)
  );

  irqc_datapath #(
    .NSRC       (NSRC),
    .VEC_W      (VEC_W),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE),
    .SRCW       (SRCW)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqFlags  (reqFlags),
    .srcEn     (srcEn),
    .globalEn  (globalEn),
    .srcPrio   (srcPrio),
    .hiAny     (hiAny),
    .loAny     (loAny),
    .ackVector (ackVector),
    .ackSrc    (ackSrc)
  );

endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
  localparam int NSRC = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rstN;
  logic             sampleStb;
  logic [NSRC-1:0]  reqFlags;
  logic             globalEn;
  logic [NSRC-1:0]  srcEn;
  logic [NSRC-1:0]  srcPrio;
  logic             lastCycle;
  logic             retiInstr;
  logic             ieIpAccess;
  logic             ackPulse;
  logic [15:0]      ackVector;
  logic [3:0]       ackSrc;
  logic             ackHigh;
  logic             inProgHigh;
  logic             inProgLow;

  irq_vector_ctrl dut_i (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .reqFlags(reqFlags),
    .globalEn(globalEn), .srcEn(srcEn), .srcPrio(srcPrio),
    .lastCycle(lastCycle), .retiInstr(retiInstr), .ieIpAccess(ieIpAccess),
    .ackPulse(ackPulse), .ackVector(ackVector), .ackSrc(ackSrc),
    .ackHigh(ackHigh), .inProgHigh(inProgHigh), .inProgLow(inProgLow)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int vecQ[$];
  string tagQ[$];

  logic [NSRC-1:0] mSampled = '0;
  bit mHigh = 1'b0;
  bit mLow  = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int lowest(input logic [NSRC-1:0] v);
    for (int i = 0; i < NSRC; i++) if (v[i]) return i;
    return -1;
  endfunction

  // driver: one machine cycle; the model predicts any acknowledge into the queue
  task automatic mcycle(input logic [NSRC-1:0] req, input bit last, input bit reti,
                        input bit acc, input string tag);
    logic [NSRC-1:0] hi;
    logic [NSRC-1:0] lo;
    bit poll;
    int w;
    hi = mSampled & srcPrio;
    lo = mSampled & ~srcPrio;
    poll = last && !reti && !acc;
    w = -1;
    if (poll && !mHigh && hi != 0) begin
      w = lowest(hi); mHigh = 1'b1;
    end else if (poll && !mHigh && !mLow && lo != 0) begin
      w = lowest(lo); mLow = 1'b1;
    end
    if (w >= 0) begin
      vecQ.push_back(3 + 8 * w);
      tagQ.push_back(tag);
    end
    if (last && reti) begin
      if (mHigh) mHigh = 1'b0;
      else mLow = 1'b0;
    end
    mSampled = req & srcEn & {NSRC{globalEn}};
    @(negedge clk);
    reqFlags = req; lastCycle = last; retiInstr = reti; ieIpAccess = acc;
    sampleStb = 1'b1;
    @(negedge clk);
    sampleStb = 1'b0; lastCycle = 1'b0; retiInstr = 1'b0; ieIpAccess = 1'b0;
    reqFlags = '1;  // R1: activity between strobes must be ignored
    repeat (2) @(negedge clk);
  endtask

  task automatic checkState(input string tag);
    check(inProgHigh == mHigh, tag, "inProgHigh", int'(inProgHigh), int'(mHigh));
    check(inProgLow == mLow, tag, "inProgLow", int'(inProgLow), int'(mLow));
    check(vecQ.size() == 0, tag, "pending acks", vecQ.size(), 0);
  endtask

  // monitor: compare each acknowledge with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && ackPulse) begin
        if (vecQ.size() == 0) begin
          check(1'b0, "R9", "unexpected ack vector", int'(ackVector), 0);
        end else begin
          int ev;
          string et;
          ev = vecQ.pop_front();
          et = tagQ.pop_front();
          check(int'(ackVector) == ev, et, "ack vector", int'(ackVector), ev);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; sampleStb = 1'b0; reqFlags = '0; globalEn = 1'b1;
    srcEn = '1; srcPrio = '0; lastCycle = 1'b0; retiInstr = 1'b0; ieIpAccess = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(ackPulse == 1'b0, "R9", "ackPulse after reset", int'(ackPulse), 0);
    check(ackVector == 16'h0, "R9", "ackVector after reset", int'(ackVector), 0);
    checkState("R9");

    // R5: every source, one at a time
    for (int i = 0; i < NSRC; i++) begin
      mcycle(NSRC'(1) << i, 1, 0, 0, "R5");
      mcycle('0, 1, 0, 0, "R5");
      checkState("R5");
      mcycle('0, 1, 1, 0, "R7");
      checkState("R7");
    end

    // R1: masked by per-source and global enables
    srcEn = ~(NSRC'(1) << 2);
    mcycle(NSRC'(1) << 2, 1, 0, 0, "R1");
    mcycle('0, 1, 0, 0, "R1");
    checkState("R1");
    srcEn = '1; globalEn = 1'b0;
    mcycle(NSRC'(1) << 6, 1, 0, 0, "R1");
    mcycle('0, 1, 0, 0, "R1");
    checkState("R1");
    globalEn = 1'b1;

    // R2: not the final cycle
    mcycle(NSRC'(1) << 1, 1, 0, 0, "R2");
    mcycle(NSRC'(1) << 1, 0, 0, 0, "R2");
    checkState("R2");
    mcycle('0, 1, 0, 0, "R2");
    checkState("R2");
    mcycle('0, 1, 1, 0, "R7");

    // R8: blocked request that disappears is lost
    mcycle(NSRC'(1) << 4, 1, 0, 0, "R8");
    mcycle('0, 0, 0, 0, "R8");
    mcycle('0, 1, 0, 0, "R8");
    checkState("R8");

    // R3: return and register access block
    mcycle(NSRC'(1) << 3, 1, 0, 0, "R3");
    mcycle(NSRC'(1) << 3, 1, 0, 1, "R3");
    checkState("R3");
    mcycle(NSRC'(1) << 3, 1, 1, 0, "R3");
    checkState("R3");
    mcycle('0, 1, 0, 0, "R3");
    checkState("R3");
    mcycle('0, 1, 1, 0, "R7");

    // R4 and R6: level first, then index; busy levels block
    srcPrio = NSRC'(1) << 9;
    mcycle(10'b10_1000_1000, 1, 0, 0, "R4");
    mcycle(10'b00_1000_1000, 1, 0, 0, "R4");
    checkState("R4");
    mcycle(10'b00_1000_1000, 1, 0, 0, "R6");
    checkState("R6");
    mcycle(10'b00_1000_1000, 1, 1, 0, "R7");
    checkState("R7");
    mcycle(10'b00_1000_0000, 1, 0, 0, "R4");
    checkState("R4");
    mcycle(10'b00_1000_0000, 1, 0, 0, "R6");
    checkState("R6");
    mcycle(10'b00_1000_0000, 1, 1, 0, "R7");
    mcycle('0, 1, 0, 0, "R4");
    checkState("R4");
    mcycle('0, 1, 1, 0, "R7");
    checkState("R7");

    // R6 and R7: high preempts low, returns unwind one level each
    srcPrio = NSRC'(1) << 8;
    mcycle(NSRC'(1) << 5, 1, 0, 0, "R6");
    mcycle(NSRC'(1) << 8, 1, 0, 0, "R6");
    mcycle('0, 1, 0, 0, "R6");
    checkState("R6");
    mcycle('0, 1, 1, 0, "R7");
    checkState("R7");
    mcycle('0, 1, 1, 0, "R7");
    checkState("R7");

    repeat (4) @(negedge clk);
    check(vecQ.size() == 0, "R9", "final queue", vecQ.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule